// File: doc/BRIEF.md
# Multi-Channel General-Purpose Timer Bank

This block holds a bank of independent 32-bit timer channels behind a plain synchronous register bus. Each channel counts pulses from one of two tick inputs, optionally halving their rate. It compares its count against a programmable value and flags an interrupt when the two meet. A channel runs in one of three behaviours: it stops after one match, it reloads to zero on every match, or it counts freely and never matches.

Software programs a channel's tick source, divider and compare value, then sets its enable bit together with a mode. It can also zero the counter in the same write. Pending flags from all channels gather in one status word. A shared mask decides which flags reach the single interrupt line, and writing ones to the status word clears the matching flags. Tick inputs are one-cycle enable pulses in the bus clock domain.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every control, clock, counter, compare, mask and pending bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Address map: mask at 0x00, pending/acknowledge at 0x08. Channel n (1..6) has control at 0x10·n, clock config at 0x10·n+4, counter at 0x10·n+8 and compare at 0x10·n+0xC. Channel n owns bit n-1 of the mask and of the pending word. `bus_rdata` shows the register addressed in the previous cycle.
- R3: Control register: bit 0 is enable and bits [5:4] are the mode (0 one-shot, 1 repeat, 3 free-running, 2 acts as one-shot). Writing 1 to bit 1 zeroes the counter and divider phase in that cycle. Bit 1 and all other bits read as 0.
- R4: Clock config: bit 4 picks the tick (0 = `tick_fast`, 1 = `tick_slow`) and bit 0 picks divide-by-2 (1) or divide-by-1 (0). Other bits read as 0.
- R5: With divide-by-2, an enabled channel advances on every second pulse of its selected tick. Pulses on the unselected tick have no effect.
- R6: In one-shot mode, an advance that makes the counter equal the compare value sets the channel's pending bit, clears its enable bit and leaves the counter at the compare value.
- R7: In repeat mode, such an advance sets the pending bit and loads 0 into the counter, and the channel stays enabled.
- R8: In free-running mode the counter advances through the full 32-bit range, wrapping to 0, and never sets the pending bit.
- R9: A write to 0x08 clears each pending bit whose data bit is 1 and leaves the others. A match in the same cycle wins over the clear. A read of 0x08 returns the pending word.
- R10: `irq` is the OR of (pending AND mask) over all channels, registered, and follows them by one cycle.
- R11: The counter register ignores bus writes, and a disabled channel's counter does not change on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_fast | input | 1 | Fast tick enable pulse |
| tick_slow | input | 1 | Slow tick enable pulse |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A tick pulse in cycle k moves the counter and any pending bit at edge k. The interrupt line follows at edge k+1. Read data is due one edge after the address is presented. The bench drives inputs at falling edges and reads `bus_rdata` just after the edge that captures it. Before checking `irq` it waits one idle cycle after every tick, mask or acknowledge write. A cycle-level model in the bench, covering enable, mode, divider phase, count and pending per channel, is advanced with the same tick pattern, so each expected value lines up with the cycle its result is due.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_RSVD   = 2'd2,
    MODE_FREE   = 2'd3
  } gpt_mode_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CLK  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CMP  = 2'd3;

  localparam logic [1:0] GLB_MASK = 2'd0;
  localparam logic [1:0] GLB_PEND = 2'd2;
endpackage

// File: rtl/gpt_divider.sv
module gpt_divider (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic src_slow,
  input  logic div2,
  input  logic tick_fast,
  input  logic tick_slow,
  output logic step
);
  logic phase;
  logic sel;

  assign sel  = src_slow ? tick_slow : tick_fast;
  assign step = run && sel && (!div2 || phase);

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= 1'b0;
    else if (run && sel) phase <= ~phase;
  end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic          clk_we,
  input  logic          cmp_we,
  input  logic [DW-1:0] wdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] clkcfg_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] cmp_q,
  output logic          hit
);
  logic          en;
  gpt_mode_e     mode;
  logic          src_slow;
  logic          div2;
  logic [DW-1:0] cnt;
  logic [DW-1:0] cmp;
  logic [DW-1:0] cnt_nxt;
  logic          step;

  gpt_divider i_div (
    .clk      (clk),
    .rst      (rst),
    .clr      (ctrl_we && wdata[1]),
    .run      (en && !ctrl_we),
    .src_slow (src_slow),
    .div2     (div2),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow),
    .step     (step)
  );

  assign cnt_nxt = cnt + 1'b1;
  assign hit     = step && (mode != MODE_FREE) && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      mode     <= MODE_ONCE;
      src_slow <= 1'b0;
      div2     <= 1'b0;
      cnt      <= '0;
      cmp      <= '0;
    end else begin
      if (clk_we) begin
        src_slow <= wdata[4];
        div2     <= wdata[0];
      end
      if (cmp_we) cmp <= wdata;
      if (ctrl_we) begin
        en   <= wdata[0];
        mode <= gpt_mode_e'(wdata[5:4]);
        if (wdata[1]) cnt <= '0;
      end else if (step) begin
        if (hit) begin
          if (mode == MODE_REPEAT) begin
            cnt <= '0;
          end else begin
            cnt <= cnt_nxt;
            en  <= 1'b0;
          end
        end else begin
          cnt <= cnt_nxt;
        end
      end
    end
  end

  always_comb begin
    ctrl_q      = '0;
    ctrl_q[0]   = en;
    ctrl_q[5:4] = mode;
    clkcfg_q    = '0;
    clkcfg_q[4] = src_slow;
    clkcfg_q[0] = div2;
  end
  assign cnt_q = cnt;
  assign cmp_q = cmp;

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    hit && (mode != MODE_REPEAT) |=> !en && (cnt == $past(cmp))); // R6
  AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    hit && (mode == MODE_REPEAT) |=> (cnt == '0) && en); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && wdata[1] |=> (cnt == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en && !ctrl_we |=> $stable(cnt)); // R11
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic         ack_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] hit,
  output logic [N-1:0] mask,
  output logic [N-1:0] pending,
  output logic         irq
);
  logic [N-1:0] ack_bits;

  assign ack_bits = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= '0;
      pending <= '0;
      irq     <= 1'b0;
    end else begin
      if (mask_we) mask <= wdata;
      pending <= (pending & ~ack_bits) | hit;
      irq     <= |(pending & mask);
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
    |hit |=> ((pending & $past(hit)) == $past(hit))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((pending & $past(wdata) & ~$past(hit)) == '0)); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(pending & mask)))); // R10
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  output logic          irq
);
  localparam int CH_W = AW - 4;

  logic [CH_W-1:0] ch_idx;
  logic [1:0]      reg_idx;
  logic            glb;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] pending;
  logic [DW-1:0] ctrl_q   [NUM_CH];
  logic [DW-1:0] clkcfg_q [NUM_CH];
  logic [DW-1:0] cnt_q    [NUM_CH];
  logic [DW-1:0] cmp_q    [NUM_CH];
  logic [DW-1:0] rd_mux;

  assign ch_idx  = bus_addr[AW-1:4];
  assign reg_idx = bus_addr[3:2];
  assign glb     = (ch_idx == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel;
    assign sel = (ch_idx == CH_W'(g + 1));
    gpt_channel #(.DW(DW)) i_ch (
      .clk      (clk),
      .rst      (rst),
      .ctrl_we  (bus_we && sel && (reg_idx == REG_CTRL)),
      .clk_we   (bus_we && sel && (reg_idx == REG_CLK)),
      .cmp_we   (bus_we && sel && (reg_idx == REG_CMP)),
      .wdata    (bus_wdata),
      .tick_fast(tick_fast),
      .tick_slow(tick_slow),
      .ctrl_q   (ctrl_q[g]),
      .clkcfg_q (clkcfg_q[g]),
      .cnt_q    (cnt_q[g]),
      .cmp_q    (cmp_q[g]),
      .hit      (hit[g])
    );
  end

  gpt_irq #(.N(NUM_CH)) i_irq (
    .clk    (clk),
    .rst    (rst),
    .mask_we(bus_we && glb && (reg_idx == GLB_MASK)),
    .ack_we (bus_we && glb && (reg_idx == GLB_PEND)),
    .wdata  (bus_wdata[NUM_CH-1:0]),
    .hit    (hit),
    .mask   (mask),
    .pending(pending),
    .irq    (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (glb) begin
      if (reg_idx == GLB_MASK) rd_mux = {{(DW-NUM_CH){1'b0}}, mask};
      else if (reg_idx == GLB_PEND) rd_mux = {{(DW-NUM_CH){1'b0}}, pending};
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CH_W'(i + 1)) begin
        case (reg_idx)
          REG_CTRL: rd_mux = ctrl_q[i];
          REG_CLK:  rd_mux = clkcfg_q[i];
          REG_CNT:  rd_mux = cnt_q[i];
          default:  rd_mux = cmp_q[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq == 1'b0) && (bus_rdata == '0)); // R1
endmodule

// File: tb/test_gp_timer_bank.sv
module test_gp_timer_bank;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic        m_en   [NCH];
  logic [1:0]  m_mode [NCH];
  logic        m_src  [NCH];
  logic        m_div  [NCH];
  logic        m_ph   [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [31:0] m_cmp  [NCH];
  logic [NCH-1:0] m_pend = '0;
  logic [NCH-1:0] m_mask = '0;

  gp_timer_bank i_gp_timer_bank (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] ch_addr(int ch, int r);
    return 8'((ch + 1) * 16 + r * 4);
  endfunction

  function automatic logic [31:0] exp_ctrl(int ch);
    return {26'd0, m_mode[ch], 3'd0, m_en[ch]};
  endfunction

  function automatic logic [31:0] exp_clk(int ch);
    return {27'd0, m_src[ch], 3'd0, m_div[ch]};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h00) m_mask = d[NCH-1:0];
    else if (a == 8'h08) m_pend = m_pend & ~d[NCH-1:0];
    else if (a[7:4] >= 1 && a[7:4] <= NCH) begin
      int c = int'(a[7:4]) - 1;
      case (a[3:2])
        2'd0: begin
          m_en[c] = d[0]; m_mode[c] = d[5:4];
          if (d[1]) begin m_cnt[c] = '0; m_ph[c] = 1'b0; end
        end
        2'd1: begin m_src[c] = d[4]; m_div[c] = d[0]; end
        2'd3: m_cmp[c] = d;
        default: ;
      endcase
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 v = bus_rdata;
  endtask

  task automatic tick(logic f, logic s);
    @(negedge clk);
    tick_fast = f; tick_slow = s;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      logic sel, old, doit;
      logic [31:0] nxt;
      sel = m_src[c] ? s : f;
      if (m_en[c] && sel) begin
        old = m_ph[c];
        m_ph[c] = ~m_ph[c];
        doit = !m_div[c] || old;
        if (doit) begin
          nxt = m_cnt[c] + 1;
          if (m_mode[c] == 2'd3) m_cnt[c] = nxt;
          else if (nxt == m_cmp[c]) begin
            m_pend[c] = 1'b1;
            if (m_mode[c] == 2'd1) m_cnt[c] = '0;
            else begin m_cnt[c] = nxt; m_en[c] = 1'b0; end
          end else m_cnt[c] = nxt;
        end
      end
    end
  endtask

  task automatic chk_irq(string req);
    @(negedge clk);
    check(req, {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
  endtask

  task automatic chk_all(string tag);
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) begin
      rd(ch_addr(c, 0), v); check({tag, " R3 ctrl"}, v, exp_ctrl(c));
      rd(ch_addr(c, 1), v); check({tag, " R4 clk"}, v, exp_clk(c));
      rd(ch_addr(c, 2), v); check({tag, " R5 cnt"}, v, m_cnt[c]);
      rd(ch_addr(c, 3), v); check({tag, " R2 cmp"}, v, m_cmp[c]);
    end
    rd(8'h00, v); check({tag, " R2 mask"}, v, {26'd0, m_mask});
    rd(8'h08, v); check({tag, " R9 pend"}, v, {26'd0, m_pend});
    chk_irq({tag, " R10 irq"});
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_mode[c] = 0; m_src[c] = 0; m_div[c] = 0;
      m_ph[c] = 0; m_cnt[c] = 0; m_cmp[c] = 0;
    end
    repeat (3) @(negedge clk);
    #1 check("R1 rdata in reset", bus_rdata, 32'd0);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    chk_all("R1 reset");

    // R3: clear bit reads back 0, mode and enable kept
    wr(ch_addr(1, 0), 32'h0000_0033);
    rd(ch_addr(1, 0), v); check("R3 ctrl readback", v, 32'h0000_0031);
    wr(ch_addr(1, 0), 32'h0);
    // R4: only bits 4 and 0 stick
    wr(ch_addr(3, 1), 32'hFFFF_FFFF);
    rd(ch_addr(3, 1), v); check("R4 clk readback", v, 32'h0000_0011);
    wr(ch_addr(3, 1), 32'h0);
    // R2: compare register full width
    wr(ch_addr(2, 3), 32'hA5C3_0F96);
    rd(ch_addr(2, 3), v); check("R2 cmp readback", v, 32'hA5C3_0F96);
    // R11: counter ignores writes
    wr(ch_addr(2, 2), 32'h1234_5678);
    rd(ch_addr(2, 2), v); check("R11 cnt write ignored", v, 32'h0);

    // R6: one-shot on channel 1
    wr(8'h00, 32'h3F);
    wr(ch_addr(0, 3), 32'd3);
    wr(ch_addr(0, 0), 32'h0000_0003);
    tick(1, 0); tick(1, 0);
    rd(8'h08, v); check("R6 no flag before match", v, 32'h0);
    tick(1, 0);
    chk_irq("R10 irq after one-shot match");
    rd(8'h08, v); check("R6 pending set", v, 32'h1);
    rd(ch_addr(0, 0), v); check("R6 enable cleared", v, 32'h0);
    tick(1, 0);
    rd(ch_addr(0, 2), v); check("R11 stopped counter holds", v, 32'd3);
    // R9: single-bit acknowledge
    wr(8'h08, 32'h1);
    rd(8'h08, v); check("R9 ack clears bit", v, 32'h0);
    chk_irq("R10 irq after ack");

    // R7: repeat on channel 2
    wr(ch_addr(1, 3), 32'd2);
    wr(ch_addr(1, 0), 32'h0000_0013);
    repeat (5) tick(1, 0);
    rd(ch_addr(1, 2), v); check("R7 reload count", v, 32'd1);
    rd(ch_addr(1, 0), v); check("R7 stays enabled", v, 32'h11);
    rd(8'h08, v); check("R7 pending", v, 32'h2);

    // R5: channel 3 on slow tick divided by two
    wr(ch_addr(2, 3), 32'd100);
    wr(ch_addr(2, 1), 32'h11);
    wr(ch_addr(2, 0), 32'h0000_0033);
    repeat (4) tick(0, 1);
    repeat (3) tick(1, 0);
    rd(ch_addr(2, 2), v); check("R5 divided slow count", v, 32'd2);

    // R8: free-running ignores compare
    wr(ch_addr(4, 3), 32'd1);
    wr(ch_addr(4, 0), 32'h0000_0033);
    repeat (4) tick(1, 0);
    rd(ch_addr(4, 2), v); check("R8 free count", v, 32'd4);
    rd(8'h08, v); check("R8 no pending", v, m_pend);

    // R9: acknowledge all
    wr(8'h08, 32'h3F);
    rd(8'h08, v); check("R9 ack all", v, 32'h0);
    chk_all("directed");

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom_range(0, 9);
      int c  = $urandom_range(0, NCH - 1);
      case (op)
        0: begin
          logic [31:0] d = {26'd0, 2'($urandom_range(0, 3)), 2'd0,
                            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0)};
          wr(ch_addr(c, 0), d);
        end
        1: wr(ch_addr(c, 1), $urandom);
        2: wr(ch_addr(c, 3), 32'($urandom_range(1, 12)));
        3: wr(8'h08, 32'($urandom_range(0, 63)));
        4: wr(8'h00, 32'($urandom_range(0, 63)));
        default: tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      endcase
      if (it % 100 == 99) chk_all("random R6 R7 R8");
      else if (op >= 3) chk_irq("random R10");
    end
    chk_all("final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule